// File: doc/BRIEF.md
# Encoder Host Command and Status Interface

This block sits between a host processor and a hardware encode engine. Software reaches it over a simple 32-bit register bus with byte offsets. It queues work by writing two words in a row to one command port: a tagged command word, then the address of the task descriptor. The block keeps each pair in a command queue and offers the oldest pair to the engine with a valid/ready handshake.

Finished tasks come back from the engine as status words carrying the same tags. They go into a status queue that software drains by reading a status port, and whose fill level is readable. Every new status entry raises a completion interrupt. A separate error interrupt reflects three captured memory error words.

When the command queue is already full, the block refuses the next command word and its descriptor. It then reports the refusal itself through a "task list full" status entry. The remaining registers (clock-gating enables, a version ID and three configuration words) are plain storage or constants. A soft reset register, with its own acknowledge flag, empties both queues.

Top module: `enc_hif`

## Requirements
- R1: After `rst_ni` is released, every readable offset returns zero except the version register, and `irq_done_o`, `irq_err_o`, `task_valid_o` and `clk_en_o` are all low.
- R2: Writes to offset 0x114 alternate between command word and descriptor. The command word is laid out as task_id in bits 31:16, client_id in bits 15:8 and command type in bits 7:0. The pair appears as `task_cmd_o`/`task_desc_o` with `task_valid_o` high. The pair stays stable until `task_ready_i` is seen high on a clock edge. Pairs leave the queue in the order they were written.
- R3: The command queue holds `CMD_DEPTH` pairs. A command word written while the queue is full is discarded, together with the descriptor write that follows it. In its place, the status word {word[31:8], 8'hF0} is pushed into the status queue, provided the status queue has room.
- R4: An engine result `res_word_i` is taken into the status queue on a clock edge where both `res_valid_i` and `res_ready_o` are high. `res_ready_o` is low while the status queue is full or a soft reset is being written. It is also low in a cycle where an overflow entry is being pushed; that entry goes in first.
- R5: A read of offset 0x118 returns the oldest status entry and removes it. A read of that offset with an empty queue returns zero and changes nothing.
- R6: Offset 0x11C returns the number of status entries in bits 3:0.
- R7: `irq_done_o` rises on the edge after any status entry is pushed. A write with bit 0 set to offset 0x120 clears it, unless an entry is pushed in the same cycle.
- R8: For each bit k of `err_strobe_i`, the edge loads `err_info_i` into error word k. Error word 0 reads at 0x128, word 1 at 0x12C and word 2 at 0x130. `irq_err_o` is high while any error word is nonzero. A write with bit 0 set to 0x124 zeroes all three words, except a word strobed in that same cycle.
- R9: Offset 0x148 stores bits 2:0 and drives them on `clk_en_o`: bit 0 enables the encoder core, bit 1 the entropy coder and bit 2 the JPEG engine. Bits 31:3 read as zero.
- R10: Offset 0x14C returns `VERSION` in bits 15:0 and zero above; writes there have no effect.
- R11: Offsets 0x108, 0x10C and 0x150 store and read back all 32 bits and have no other effect.
- R12: A write with bit 0 set to 0x100 empties both queues, makes the next command-port write a command word, and clears both interrupts and all error words. From the next cycle, offset 0x104 reads 1 until any write to 0x104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| task_valid_o | output | 1 | A queued task is offered |
| task_ready_i | input | 1 | Engine takes the offered task |
| task_cmd_o | output | 32 | Command word of the offered task |
| task_desc_o | output | 32 | Descriptor address of the offered task |
| res_valid_i | input | 1 | Engine offers a status word |
| res_ready_o | output | 1 | Status word accepted this cycle |
| res_word_i | input | 32 | Status word: task_id 31:16, client_id 15:8, code 7:0 |
| err_strobe_i | input | 3 | Load strobe per error word |
| err_info_i | input | 32 | Error value to load |
| irq_done_o | output | 1 | Completion interrupt |
| irq_err_o | output | 1 | Error interrupt |
| clk_en_o | output | 3 | Clock enables for core, entropy coder, JPEG engine |

## Verification
Overflow reporting and acceptance of an engine result both push into the status queue, and they can fall in the same cycle. The bench fills the command queue, then holds `res_valid_i` high in the same cycle as a command word write to the full queue. It expects `res_ready_o` low in that cycle and high in the next. It then expects the refusal entry to read out of the status port ahead of the engine result. A completion-interrupt acknowledge coinciding with a result push is provoked the same way, and the bench expects the interrupt to stay set.

// File: rtl/enc_hif_pkg.sv
package enc_hif_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned OFF_RST   = 'h100;
  localparam int unsigned OFF_RACK  = 'h104;
  localparam int unsigned OFF_MCFG  = 'h108;
  localparam int unsigned OFF_MCFG2 = 'h10C;
  localparam int unsigned OFF_CMD   = 'h114;
  localparam int unsigned OFF_STS   = 'h118;
  localparam int unsigned OFF_LVL   = 'h11C;
  localparam int unsigned OFF_DACK  = 'h120;
  localparam int unsigned OFF_EACK  = 'h124;
  localparam int unsigned OFF_ELOC  = 'h128;
  localparam int unsigned OFF_EEXT  = 'h12C;
  localparam int unsigned OFF_ESEC  = 'h130;
  localparam int unsigned OFF_CG    = 'h148;
  localparam int unsigned OFF_VER   = 'h14C;
  localparam int unsigned OFF_SWAP  = 'h150;

  localparam logic [7:0] ST_LIST_FULL = 8'hF0;

  typedef struct packed {
    logic [15:0] task_id;
    logic [7:0]  client_id;
    logic [7:0]  code;
  } tag_word_t;
endpackage

// File: rtl/enc_hif_fifo.sv
module enc_hif_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (count_o != CW'(DEPTH));
  assign pop_ok  = pop_i && (count_o != '0);
  assign rdata_o = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      if (push_ok && !pop_ok)      count_o <= count_o + CW'(1);
      else if (pop_ok && !push_ok) count_o <= count_o - CW'(1);
    end
  end
endmodule

// File: rtl/enc_hif_errcap.sv
module enc_hif_errcap #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        strobe_i,
  input  logic [W-1:0]        info_i,
  input  logic                clear_i,
  output logic [N-1:0][W-1:0] err_o,
  output logic                irq_o
);
  for (genvar k = 0; k < N; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          err_o[k] <= '0;
      else if (strobe_i[k]) err_o[k] <= info_i;   // new error beats clear
      else if (clear_i)     err_o[k] <= '0;
    end
  end

  assign irq_o = |err_o;
endmodule

// File: rtl/enc_hif.sv
module enc_hif
  import enc_hif_pkg::*;
#(
  parameter int unsigned CMD_DEPTH = 4,
  parameter int unsigned STS_DEPTH = 8,
  parameter int unsigned AW        = 12,
  parameter logic [15:0] VERSION   = 16'h0A51
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          task_valid_o,
  input  logic          task_ready_i,
  output logic [DW-1:0] task_cmd_o,
  output logic [DW-1:0] task_desc_o,
  input  logic          res_valid_i,
  output logic          res_ready_o,
  input  logic [DW-1:0] res_word_i,
  input  logic [2:0]    err_strobe_i,
  input  logic [DW-1:0] err_info_i,
  output logic          irq_done_o,
  output logic          irq_err_o,
  output logic [2:0]    clk_en_o
);
  localparam int unsigned CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int unsigned STS_CW = $clog2(STS_DEPTH + 1);
  localparam int unsigned LVL_W  = 4;
  localparam int unsigned N_ERR  = 3;
  localparam int unsigned N_CG   = 3;

  logic wr, rd, cmd_wr, srst, dack, eack;
  logic phase_q, drop_q, rack_q;
  logic [DW-1:0] hold_q, mcfg_q, mcfg2_q, swap_q;
  logic [N_CG-1:0] cg_q;
  logic [CMD_CW-1:0] cmd_cnt;
  logic [STS_CW-1:0] sts_cnt;
  logic [2*DW-1:0] cmd_head;
  logic [DW-1:0] sts_head, sts_wdata;
  logic cmd_full, sts_full, sts_empty;
  logic cmd_push, ovf_push, sts_push, sts_pop;
  logic [N_ERR-1:0][DW-1:0] err_q;
  tag_word_t ovf_w;

  assign wr     = req_i && we_i;
  assign rd     = req_i && !we_i;
  assign cmd_wr = wr && (addr_i == AW'(OFF_CMD));
  assign srst   = wr && (addr_i == AW'(OFF_RST))  && wdata_i[0];
  assign dack   = wr && (addr_i == AW'(OFF_DACK)) && wdata_i[0];
  assign eack   = wr && (addr_i == AW'(OFF_EACK)) && wdata_i[0];

  assign cmd_full  = (cmd_cnt == CMD_CW'(CMD_DEPTH));
  assign sts_full  = (sts_cnt == STS_CW'(STS_DEPTH));
  assign sts_empty = (sts_cnt == '0);

  // command port: word then descriptor; full is judged at the word
  assign cmd_push = cmd_wr && phase_q && !drop_q;
  assign ovf_push = cmd_wr && !phase_q && cmd_full;

  assign ovf_w       = '{task_id: wdata_i[31:16], client_id: wdata_i[15:8], code: ST_LIST_FULL};
  assign res_ready_o = !sts_full && !ovf_push && !srst;
  assign sts_push    = !srst && !sts_full && (ovf_push || res_valid_i);
  assign sts_wdata   = ovf_push ? DW'(ovf_w) : res_word_i;
  assign sts_pop     = rd && (addr_i == AW'(OFF_STS)) && !sts_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      drop_q  <= 1'b0;
      hold_q  <= '0;
    end else if (srst) begin
      phase_q <= 1'b0;
      drop_q  <= 1'b0;
    end else if (cmd_wr) begin
      phase_q <= !phase_q;
      if (!phase_q) begin
        hold_q <= wdata_i;
        drop_q <= cmd_full;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcfg_q  <= '0;
      mcfg2_q <= '0;
      swap_q  <= '0;
      cg_q    <= '0;
    end else if (wr) begin
      if (addr_i == AW'(OFF_MCFG))  mcfg_q  <= wdata_i;
      if (addr_i == AW'(OFF_MCFG2)) mcfg2_q <= wdata_i;
      if (addr_i == AW'(OFF_SWAP))  swap_q  <= wdata_i;
      if (addr_i == AW'(OFF_CG))    cg_q    <= wdata_i[N_CG-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rack_q <= 1'b0;
    else if (srst)                              rack_q <= 1'b1;
    else if (wr && addr_i == AW'(OFF_RACK))     rack_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          irq_done_o <= 1'b0;
    else if (sts_push)    irq_done_o <= 1'b1;
    else if (dack || srst) irq_done_o <= 1'b0;
  end

  enc_hif_fifo #(.WIDTH(2*DW), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni, .flush_i(srst), .push_i(cmd_push),
    .wdata_i({hold_q, wdata_i}), .pop_i(task_valid_o && task_ready_i),
    .rdata_o(cmd_head), .count_o(cmd_cnt)
  );

  enc_hif_fifo #(.WIDTH(DW), .DEPTH(STS_DEPTH)) u_sts_q (
    .clk_i, .rst_ni, .flush_i(srst), .push_i(sts_push),
    .wdata_i(sts_wdata), .pop_i(sts_pop),
    .rdata_o(sts_head), .count_o(sts_cnt)
  );

  enc_hif_errcap #(.N(N_ERR), .W(DW)) u_err (
    .clk_i, .rst_ni, .strobe_i(err_strobe_i), .info_i(err_info_i),
    .clear_i(eack || srst), .err_o(err_q), .irq_o(irq_err_o)
  );

  assign task_valid_o = (cmd_cnt != '0);
  assign task_cmd_o   = cmd_head[2*DW-1:DW];
  assign task_desc_o  = cmd_head[DW-1:0];
  assign clk_en_o     = cg_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      AW'(OFF_RACK):  rdata_o = DW'(rack_q);
      AW'(OFF_MCFG):  rdata_o = mcfg_q;
      AW'(OFF_MCFG2): rdata_o = mcfg2_q;
      AW'(OFF_STS):   rdata_o = sts_empty ? '0 : sts_head;
      AW'(OFF_LVL):   rdata_o = DW'(LVL_W'(sts_cnt));
      AW'(OFF_ELOC):  rdata_o = err_q[0];
      AW'(OFF_EEXT):  rdata_o = err_q[1];
      AW'(OFF_ESEC):  rdata_o = err_q[2];
      AW'(OFF_CG):    rdata_o = DW'(cg_q);
      AW'(OFF_VER):   rdata_o = DW'(VERSION);
      AW'(OFF_SWAP):  rdata_o = swap_q;
      default:        rdata_o = '0;
    endcase
  end
endmodule

module enc_hif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sts_full,
  input logic        sts_empty,
  input logic        sts_push,
  input logic        ovf_push,
  input logic        srst,
  input logic        irq_done_o,
  input logic        irq_err_o,
  input logic        task_valid_o,
  input logic        task_ready_i,
  input logic [31:0] task_cmd_o,
  input logic [31:0] task_desc_o,
  input logic [2:0]  err_strobe_i,
  input logic [31:0] err_info_i
);
  AST_STS_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_full |-> !sts_push);  // R4
  AST_OVF_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_push && !sts_full) |=> !sts_empty);  // R3
  AST_TASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_valid_o && !task_ready_i && !srst) |=>
      (task_valid_o && $stable(task_cmd_o) && $stable(task_desc_o)));  // R2
  AST_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_push |=> irq_done_o);  // R7
  AST_ERR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|err_strobe_i) && (err_info_i != '0)) |=> irq_err_o);  // R8
  AST_SRST_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (!task_valid_o && sts_empty && !irq_done_o));  // R12
endmodule

bind enc_hif enc_hif_chk u_chk (
  .clk_i, .rst_ni, .sts_full, .sts_empty, .sts_push, .ovf_push, .srst,
  .irq_done_o, .irq_err_o, .task_valid_o, .task_ready_i,
  .task_cmd_o, .task_desc_o, .err_strobe_i, .err_info_i
);

// File: tb/sim_enc_hif.sv
module sim_enc_hif;
  import enc_hif_pkg::*;
  localparam int unsigned CMD_DEPTH = 4;
  localparam int unsigned STS_DEPTH = 8;
  localparam logic [15:0] VER = 16'h0A51;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic task_valid, task_ready = 0;
  logic [31:0] task_cmd, task_desc;
  logic res_valid = 0, res_ready;
  logic [31:0] res_word = '0;
  logic [2:0] err_strobe = '0;
  logic [31:0] err_info = '0;
  logic irq_done, irq_err;
  logic [2:0] clk_en;

  int n_chk = 0, n_fail = 0;
  logic [63:0] m_cmd[$];
  logic [31:0] m_sts[$];
  logic m_irq = 0;

  always #2 clk = ~clk;

  enc_hif #(.CMD_DEPTH(CMD_DEPTH), .STS_DEPTH(STS_DEPTH), .AW(12), .VERSION(VER)) u0 (
    .clk_i(clk), .rst_ni, .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .task_valid_o(task_valid), .task_ready_i(task_ready),
    .task_cmd_o(task_cmd), .task_desc_o(task_desc), .res_valid_i(res_valid),
    .res_ready_o(res_ready), .res_word_i(res_word), .err_strobe_i(err_strobe),
    .err_info_i(err_info), .irq_done_o(irq_done), .irq_err_o(irq_err), .clk_en_o(clk_en)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ovf_word(input logic [31:0] w);
    return {w[31:8], 8'hF0};
  endfunction

  task automatic bus_wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = 12'(a); wdata = d;
    @(posedge clk); #1 req = 0; we = 0;
  endtask

  task automatic bus_rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = 12'(a);
    #1 d = rdata;
    @(posedge clk); #1 req = 0;
  endtask

  task automatic rd_chk(input string tag, input int unsigned a, input logic [31:0] exp);
    logic [31:0] d;
    bus_rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic cmd_pair(input logic [31:0] w0, input logic [31:0] w1);
    bit drop;
    bus_wr(OFF_CMD, w0);
    drop = (m_cmd.size() == CMD_DEPTH);
    if (drop && m_sts.size() < STS_DEPTH) begin
      m_sts.push_back(ovf_word(w0));
      m_irq = 1;
    end
    bus_wr(OFF_CMD, w1);
    if (!drop) m_cmd.push_back({w0, w1});
  endtask

  task automatic eng_take();
    if (m_cmd.size() == 0) begin
      chk("R2 idle valid", 64'(task_valid), 64'd0);
    end else begin
      @(negedge clk); task_ready = 1;
      #1 chk("R2 valid", 64'(task_valid), 64'd1);
      chk("R2 pair", {task_cmd, task_desc}, m_cmd[0]);
      @(posedge clk); #1 task_ready = 0;
      void'(m_cmd.pop_front());
    end
  endtask

  task automatic eng_result(input logic [31:0] w);
    bit exp_rdy;
    @(negedge clk); res_valid = 1; res_word = w;
    exp_rdy = (m_sts.size() < STS_DEPTH);
    #1 chk("R4 ready", 64'(res_ready), 64'(exp_rdy));
    @(posedge clk); #1 res_valid = 0;
    if (exp_rdy) begin m_sts.push_back(w); m_irq = 1; end
  endtask

  task automatic sts_read();
    logic [31:0] exp;
    exp = (m_sts.size() == 0) ? 32'd0 : m_sts.pop_front();
    rd_chk("R5 status", OFF_STS, exp);
  endtask

  task automatic strobe(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk); err_strobe = s; err_info = v;
    @(posedge clk); #1 err_strobe = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_ni = 1;

    // R1 reset state
    chk("R1 irq_done", 64'(irq_done), 0);
    chk("R1 irq_err", 64'(irq_err), 0);
    chk("R1 task_valid", 64'(task_valid), 0);
    chk("R1 clk_en", 64'(clk_en), 0);
    rd_chk("R1 rack", OFF_RACK, 0);
    rd_chk("R1 mcfg", OFF_MCFG, 0);
    rd_chk("R1 swap", OFF_SWAP, 0);
    rd_chk("R1 level", OFF_LVL, 0);
    rd_chk("R1 eloc", OFF_ELOC, 0);
    rd_chk("R1 cg", OFF_CG, 0);
    rd_chk("R1 sts", OFF_STS, 0);
    rd_chk("R10 version", OFF_VER, {16'h0, VER});
    bus_wr(OFF_VER, 32'hFFFF_FFFF);
    rd_chk("R10 version ro", OFF_VER, {16'h0, VER});

    // R11 config storage
    begin
      logic [31:0] a = $urandom(), b = $urandom(), c = $urandom();
      bus_wr(OFF_MCFG, a); bus_wr(OFF_MCFG2, b); bus_wr(OFF_SWAP, c);
      rd_chk("R11 mcfg", OFF_MCFG, a);
      rd_chk("R11 mcfg2", OFF_MCFG2, b);
      rd_chk("R11 swap", OFF_SWAP, c);
      rd_chk("R11 no level", OFF_LVL, 0);
      chk("R11 no task", 64'(task_valid), 0);
    end

    // R9 clock gating
    bus_wr(OFF_CG, 32'hFFFF_FFFF);
    rd_chk("R9 cg mask", OFF_CG, 32'h7);
    chk("R9 clk_en", 64'(clk_en), 64'h7);
    bus_wr(OFF_CG, 32'h5);
    chk("R9 clk_en 5", 64'(clk_en), 64'h5);

    // R5 empty read
    sts_read();
    rd_chk("R6 level empty", OFF_LVL, 0);

    // R2 ordering and R3 overflow with same-cycle result (R4)
    for (int i = 0; i < CMD_DEPTH; i++) cmd_pair($urandom(), $urandom());
    chk("R3 full valid", 64'(task_valid), 1);
    begin
      logic [31:0] w = 32'h1234_56AB, r = 32'h0042_0708, dsc = 32'hCAFE_0000;
      @(negedge clk); req = 1; we = 1; addr = 12'(OFF_CMD); wdata = w;
      res_valid = 1; res_word = r;
      #1 chk("R4 ready low on overflow", 64'(res_ready), 0);
      @(posedge clk); #1 req = 0; we = 0;
      #1 chk("R4 ready after overflow", 64'(res_ready), 1);
      @(posedge clk); #1 res_valid = 0;
      m_sts.push_back(ovf_word(w)); m_sts.push_back(r); m_irq = 1;
      bus_wr(OFF_CMD, dsc);
      chk("R7 irq set", 64'(irq_done), 1);
      rd_chk("R6 level two", OFF_LVL, 2);
      sts_read(); sts_read();
    end
    for (int i = 0; i < CMD_DEPTH; i++) eng_take();
    chk("R3 descriptor dropped", 64'(task_valid), 0);

    // R7 ack coinciding with push keeps irq set; plain ack clears
    @(negedge clk); req = 1; we = 1; addr = 12'(OFF_DACK); wdata = 1;
    res_valid = 1; res_word = 32'h0001_0200;
    @(posedge clk); #1 req = 0; we = 0; res_valid = 0;
    m_sts.push_back(32'h0001_0200);
    chk("R7 push beats ack", 64'(irq_done), 1);
    bus_wr(OFF_DACK, 1); m_irq = 0;
    chk("R7 ack clears", 64'(irq_done), 0);
    sts_read();

    // R4 full status queue backpressure
    for (int i = 0; i < STS_DEPTH + 1; i++) eng_result($urandom());
    rd_chk("R6 level full", OFF_LVL, STS_DEPTH);
    for (int i = 0; i < STS_DEPTH; i++) sts_read();

    // R8 errors
    strobe(3'b010, 32'hDEAD_0001);
    rd_chk("R8 ext", OFF_EEXT, 32'hDEAD_0001);
    chk("R8 irq_err", 64'(irq_err), 1);
    @(negedge clk); req = 1; we = 1; addr = 12'(OFF_EACK); wdata = 1;
    err_strobe = 3'b001; err_info = 32'h55;
    @(posedge clk); #1 req = 0; we = 0; err_strobe = 0;
    rd_chk("R8 strobe beats ack", OFF_ELOC, 32'h55);
    rd_chk("R8 ack zeroes", OFF_EEXT, 0);
    chk("R8 irq_err held", 64'(irq_err), 1);
    bus_wr(OFF_EACK, 1);
    chk("R8 irq_err cleared", 64'(irq_err), 0);
    strobe(3'b100, 32'h77);
    rd_chk("R8 sec", OFF_ESEC, 32'h77);

    // R12 soft reset
    cmd_pair(32'hAAAA_0101, 32'hBBBB_0000);
    eng_result(32'h0000_0008);
    bus_wr(OFF_CMD, 32'h9999_0001);
    bus_wr(OFF_RST, 1);
    m_cmd.delete(); m_sts.delete(); m_irq = 0;
    chk("R12 no task", 64'(task_valid), 0);
    chk("R12 irq_done", 64'(irq_done), 0);
    chk("R12 irq_err", 64'(irq_err), 0);
    rd_chk("R12 level", OFF_LVL, 0);
    rd_chk("R12 err cleared", OFF_ESEC, 0);
    rd_chk("R12 rack set", OFF_RACK, 1);
    bus_wr(OFF_RACK, 0);
    rd_chk("R12 rack cleared", OFF_RACK, 0);
    cmd_pair(32'h0003_0201, 32'h8000_1000);
    eng_take();

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 5))
        0: cmd_pair($urandom(), $urandom());
        1: eng_take();
        2: eng_result($urandom());
        3: sts_read();
        4: rd_chk("R6 level", OFF_LVL, 32'(m_sts.size()));
        default: begin
          chk("R7 irq model", 64'(irq_done), 64'(m_irq));
          if ($urandom_range(0, 1) == 1) begin bus_wr(OFF_DACK, 1); m_irq = 0; end
        end
      endcase
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule